// File: doc/BRIEF.md
# External Bus Bridge with Timeout and Lane Swap

This block connects a simple internal request bus to an external 32-bit Wishbone master port. An internal requester raises a request together with an address, write data, byte enables and a write flag. The bridge opens one external cycle, waits for the slave to acknowledge or report an error, and returns a one-cycle acknowledge or error pulse with the read data. Only one transfer is in flight at a time. While a cycle is open, `req_ready_o` is low and further requests are not taken. The requester keeps its request raised until it is accepted.

Build-time parameters set the strobe style (classic or pipelined), the external byte order, whether the response path and the request path are registered or direct, and a watchdog limit. The watchdog ends a cycle that the slave never answers and reports it as a fault.

Top module: `wb_bridge`

## Requirements
- R1: After synchronous active-high reset, `wb_cyc_o`, `wb_stb_o`, `rsp_ack_o` and `rsp_err_o` are low and `req_ready_o` is high.
- R2: Classic mode (`PIPELINED`=0): strobe and cycle rise together and stay high until the acknowledge is sampled. They fall one cycle later, so for a slave that acknowledges after a delay of D the cycle is visible for D+2 clocks.
- R3: Pipelined mode (`PIPELINED`=1): the strobe is high for exactly one clock per transfer, and the cycle stays high until acknowledge or error.
- R4: During a read, the address is held stable and `wb_we_o` is low for the whole cycle. The read data is returned with the acknowledge.
- R5: During a write, the address, the write data, the byte select and `wb_we_o`=1 are held stable for the whole cycle. The write acknowledge returns zero read data.
- R6: An error input ends the cycle like an acknowledge, but it raises `rsp_err_o` instead of `rsp_ack_o` and returns zero read data.
- R7: With `TIMEOUT`=N>0 and no reply from the slave, the cycle is visible for N clocks. It then drops and an error with zero read data is returned.
- R8: With `TIMEOUT`=0, an unanswered cycle stays open indefinitely and no response is produced until the slave replies.
- R9: With `BIG_ENDIAN`=1, byte lane k (bits 8k+7:8k) of the internal write data, read data and byte enables maps to external lane 3-k. With `BIG_ENDIAN`=0 the lanes pass through unchanged.
- R10: `RX_DIRECT`=0 gives the response one clock after the slave's acknowledge is sampled, when the cycle is already low. `RX_DIRECT`=1 gives it in the same clock, while the cycle is still high.
- R11: `TX_DIRECT`=0 raises the cycle one clock after the request is accepted. `TX_DIRECT`=1 raises it combinationally in the clock of acceptance.
- R12: While a cycle is open, `req_ready_o` is low and a raised request is ignored: the external address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Internal request strobe |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Request address |
| req_wdata_i | input | 32 | Write data, little-endian lanes |
| req_ben_i | input | 4 | Byte enables, bit k = lane k |
| req_ready_o | output | 1 | Bridge idle, request will be taken |
| rsp_rdata_o | output | 32 | Read data (zero unless a read is acknowledged) |
| rsp_ack_o | output | 1 | Transfer done without fault |
| rsp_err_o | output | 1 | Transfer ended by error or timeout |
| wb_adr_o | output | 32 | External address |
| wb_dat_o | output | 32 | External write data |
| wb_we_o | output | 1 | External write enable |
| wb_sel_o | output | 4 | External byte select |
| wb_stb_o | output | 1 | External strobe |
| wb_cyc_o | output | 1 | External cycle valid |
| wb_dat_i | input | 32 | External read data |
| wb_ack_i | input | 1 | External acknowledge |
| wb_err_i | input | 1 | External error |

## Verification
The hardest situations to reach are a slave that never replies and a second request that arrives while a cycle is open. The bench's slave model has a silent mode for this. In that mode the watchdog must end the cycle after exactly N visible clocks, and the bench raises a fresh request with a different address during the stall to show that it is ignored. With the watchdog disabled, the bench holds the stall for forty clocks, confirms that nothing comes back, and then switches the slave to answer so that the pending response can still be checked.

// File: rtl/wb_bridge.sv
module wb_bridge #(
  parameter int unsigned TIMEOUT    = 16,
  parameter bit          PIPELINED  = 1'b0,
  parameter bit          BIG_ENDIAN = 1'b0,
  parameter bit          RX_DIRECT  = 1'b0,
  parameter bit          TX_DIRECT  = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_i,
  input  logic        req_we_i,
  input  logic [31:0] req_addr_i,
  input  logic [31:0] req_wdata_i,
  input  logic [3:0]  req_ben_i,
  output logic        req_ready_o,
  output logic [31:0] rsp_rdata_o,
  output logic        rsp_ack_o,
  output logic        rsp_err_o,
  output logic [31:0] wb_adr_o,
  output logic [31:0] wb_dat_o,
  output logic        wb_we_o,
  output logic [3:0]  wb_sel_o,
  output logic        wb_stb_o,
  output logic        wb_cyc_o,
  input  logic [31:0] wb_dat_i,
  input  logic        wb_ack_i,
  input  logic        wb_err_i
);
  localparam int NB   = 4;
  localparam int CW   = (TIMEOUT > 1) ? $clog2(TIMEOUT) + 1 : 1;
  localparam int TLIM = (TIMEOUT == 0) ? 0 : int'(TIMEOUT) - 1;

  function automatic logic [31:0] swap_data(input logic [31:0] v);
    logic [31:0] r;
    for (int k = 0; k < NB; k++)
      r[8*k +: 8] = BIG_ENDIAN ? v[8*(NB-1-k) +: 8] : v[8*k +: 8];
    return r;
  endfunction

  function automatic logic [3:0] swap_sel(input logic [3:0] v);
    logic [3:0] r;
    for (int k = 0; k < NB; k++)
      r[k] = BIG_ENDIAN ? v[NB-1-k] : v[k];
    return r;
  endfunction

  logic          cyc_q, stb_q, we_q;
  logic [31:0]   adr_q, dat_q;
  logic [3:0]    sel_q;
  logic [CW-1:0] cnt_q;

  logic        acc, tmo_hit, ack_ev, err_ev, term;
  logic [31:0] rd_ev;

  assign acc     = req_i & ~cyc_q;
  assign tmo_hit = (TIMEOUT != 0) && (cnt_q >= CW'(TLIM));
  assign ack_ev  = cyc_q & wb_ack_i & ~wb_err_i;
  assign err_ev  = cyc_q & (wb_err_i | (tmo_hit & ~wb_ack_i));
  assign term    = ack_ev | err_ev;
  assign rd_ev   = (ack_ev & ~we_q) ? swap_data(wb_dat_i) : 32'h0;
  assign req_ready_o = ~cyc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= 1'b0;
      stb_q <= 1'b0;
      we_q  <= 1'b0;
      adr_q <= '0;
      dat_q <= '0;
      sel_q <= '0;
      cnt_q <= '0;
    end else if (acc) begin
      cyc_q <= 1'b1;
      stb_q <= !(PIPELINED && TX_DIRECT);
      we_q  <= req_we_i;
      adr_q <= req_addr_i;
      dat_q <= swap_data(req_wdata_i);
      sel_q <= swap_sel(req_ben_i);
      cnt_q <= CW'(TX_DIRECT);
    end else if (cyc_q) begin
      if (term) begin
        cyc_q <= 1'b0;
        stb_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        if (PIPELINED) stb_q <= 1'b0;
        if (TIMEOUT != 0) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  generate
    if (TX_DIRECT) begin : g_tx_dir
      assign wb_cyc_o = cyc_q | acc;
      assign wb_stb_o = stb_q | acc;
      assign wb_we_o  = acc ? req_we_i : we_q;
      assign wb_adr_o = acc ? req_addr_i : adr_q;
      assign wb_dat_o = acc ? swap_data(req_wdata_i) : dat_q;
      assign wb_sel_o = acc ? swap_sel(req_ben_i) : sel_q;
    end else begin : g_tx_reg
      assign wb_cyc_o = cyc_q;
      assign wb_stb_o = stb_q;
      assign wb_we_o  = we_q;
      assign wb_adr_o = adr_q;
      assign wb_dat_o = dat_q;
      assign wb_sel_o = sel_q;
    end

    if (RX_DIRECT) begin : g_rx_dir
      assign rsp_ack_o   = ack_ev;
      assign rsp_err_o   = err_ev;
      assign rsp_rdata_o = rd_ev;
    end else begin : g_rx_reg
      logic        ack_q, err_q;
      logic [31:0] rd_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          ack_q <= 1'b0;
          err_q <= 1'b0;
          rd_q  <= '0;
        end else begin
          ack_q <= ack_ev;
          err_q <= err_ev;
          rd_q  <= rd_ev;
        end
      end
      assign rsp_ack_o   = ack_q;
      assign rsp_err_o   = err_q;
      assign rsp_rdata_o = rd_q;
    end

    if (PIPELINED) begin : g_chk_pipe
      // R3
      stb_single_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_stb_o && !wb_ack_i && !wb_err_i) |=> !wb_stb_o);
    end else begin : g_chk_classic
      // R2
      stb_cyc_pair_chk: assert property (@(posedge clk) disable iff (rst)
        wb_stb_o == wb_cyc_o);
    end

    if (TIMEOUT != 0) begin : g_chk_tmo
      // R7
      tmo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_q |-> (cnt_q <= CW'(TLIM)));
    end
  endgenerate

  // R3
  stb_in_cyc_chk: assert property (@(posedge clk) disable iff (rst)
    wb_stb_o |-> wb_cyc_o);

  // R4
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_q && $past(cyc_q)) |-> ($stable(wb_adr_o) && $stable(wb_we_o) &&
                                 $stable(wb_dat_o) && $stable(wb_sel_o)));

  // R6
  rsp_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rsp_ack_o && rsp_err_o));

  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_err_o |-> (rsp_rdata_o == 32'h0));

  // R12
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_q |-> !req_ready_o);
endmodule

// File: tb/sim_wb_bridge.sv
module sim_slave (
  input  logic        clk,
  input  logic        rst,
  input  logic        cyc,
  input  logic        stb,
  input  logic        we,
  input  logic [31:0] adr,
  input  logic [31:0] dat_w,
  input  logic [3:0]  sel,
  input  int          mode,
  input  int          delay,
  input  logic [31:0] rd,
  output logic        ack,
  output logic        err,
  output logic [31:0] dat_r,
  output logic [31:0] cap_adr,
  output logic [31:0] cap_dat,
  output logic [3:0]  cap_sel,
  output logic        cap_we
);
  int cnt;
  assign dat_r = ack ? rd : 32'hA5A5_5A5A;
  always_ff @(posedge clk) begin
    if (rst) begin
      ack <= 1'b0; err <= 1'b0; cnt <= 0;
      cap_adr <= '0; cap_dat <= '0; cap_sel <= '0; cap_we <= 1'b0;
    end else begin
      if (cyc && stb) begin
        cap_adr <= adr; cap_dat <= dat_w; cap_sel <= sel; cap_we <= we;
      end
      if (ack || err) begin
        ack <= 1'b0; err <= 1'b0; cnt <= 0;
      end else if (cyc) begin
        if (cnt >= delay && mode < 2) begin
          ack <= (mode == 0); err <= (mode == 1);
        end else cnt <= cnt + 1;
      end else cnt <= 0;
    end
  end
endmodule

module sim_wb_bridge;
  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst;

  logic        req [2], we [2], ready [2], rack [2], rerr [2];
  logic [31:0] addr [2], wdata [2], rdata [2];
  logic [3:0]  ben [2];
  logic [31:0] wadr [2], wdo [2], wdi [2];
  logic        wwe [2], wstb [2], wcyc [2], wack [2], werr [2];
  logic [3:0]  wsel [2];
  int          smode [2], sdelay [2];
  logic [31:0] srd [2];
  logic [31:0] cadr [2], cdat [2];
  logic [3:0]  csel [2];
  logic        cwe [2];

  wb_bridge #(.TIMEOUT(6)) u0 (
    .clk(clk), .rst(rst), .req_i(req[0]), .req_we_i(we[0]), .req_addr_i(addr[0]),
    .req_wdata_i(wdata[0]), .req_ben_i(ben[0]), .req_ready_o(ready[0]),
    .rsp_rdata_o(rdata[0]), .rsp_ack_o(rack[0]), .rsp_err_o(rerr[0]),
    .wb_adr_o(wadr[0]), .wb_dat_o(wdo[0]), .wb_we_o(wwe[0]), .wb_sel_o(wsel[0]),
    .wb_stb_o(wstb[0]), .wb_cyc_o(wcyc[0]), .wb_dat_i(wdi[0]), .wb_ack_i(wack[0]),
    .wb_err_i(werr[0]));

  wb_bridge #(.TIMEOUT(0), .PIPELINED(1), .BIG_ENDIAN(1), .RX_DIRECT(1), .TX_DIRECT(1)) u1 (
    .clk(clk), .rst(rst), .req_i(req[1]), .req_we_i(we[1]), .req_addr_i(addr[1]),
    .req_wdata_i(wdata[1]), .req_ben_i(ben[1]), .req_ready_o(ready[1]),
    .rsp_rdata_o(rdata[1]), .rsp_ack_o(rack[1]), .rsp_err_o(rerr[1]),
    .wb_adr_o(wadr[1]), .wb_dat_o(wdo[1]), .wb_we_o(wwe[1]), .wb_sel_o(wsel[1]),
    .wb_stb_o(wstb[1]), .wb_cyc_o(wcyc[1]), .wb_dat_i(wdi[1]), .wb_ack_i(wack[1]),
    .wb_err_i(werr[1]));

  sim_slave s0 (.clk(clk), .rst(rst), .cyc(wcyc[0]), .stb(wstb[0]), .we(wwe[0]),
    .adr(wadr[0]), .dat_w(wdo[0]), .sel(wsel[0]), .mode(smode[0]), .delay(sdelay[0]),
    .rd(srd[0]), .ack(wack[0]), .err(werr[0]), .dat_r(wdi[0]), .cap_adr(cadr[0]),
    .cap_dat(cdat[0]), .cap_sel(csel[0]), .cap_we(cwe[0]));

  sim_slave s1 (.clk(clk), .rst(rst), .cyc(wcyc[1]), .stb(wstb[1]), .we(wwe[1]),
    .adr(wadr[1]), .dat_w(wdo[1]), .sel(wsel[1]), .mode(smode[1]), .delay(sdelay[1]),
    .rd(srd[1]), .ack(wack[1]), .err(werr[1]), .dat_r(wdi[1]), .cap_adr(cadr[1]),
    .cap_dat(cdat[1]), .cap_sel(csel[1]), .cap_we(cwe[1]));

  typedef struct {
    bit          err;
    logic [31:0] rd;
    string       tag;
  } exp_t;
  exp_t q0[$], q1[$];

  int checks = 0, errors = 0;
  int clen [2], scnt [2];
  bit got [2], rcyc [2];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      for (int d = 0; d < 2; d++) begin
        if (wcyc[d]) clen[d]++;
        if (wstb[d]) scnt[d]++;
        if (rack[d] || rerr[d]) begin
          exp_t e;
          got[d]  = 1'b1;
          rcyc[d] = wcyc[d];
          if ((d == 0 && q0.size() == 0) || (d == 1 && q1.size() == 0))
            chk(1'b0, "R8 unexpected response", {30'd0, rack[d], rerr[d]}, 32'd0);
          else begin
            e = (d == 0) ? q0.pop_front() : q1.pop_front();
            chk(rerr[d] == e.err && rack[d] == !e.err, e.tag,
                {30'd0, rack[d], rerr[d]}, {30'd0, !e.err, e.err});
            chk(rdata[d] == e.rd, e.tag, rdata[d], e.rd);
          end
        end
      end
    end
  end

  task automatic push(input int d, input bit e, input logic [31:0] rdv, input string tag);
    exp_t x;
    x.err = e; x.rd = rdv; x.tag = tag;
    if (d == 0) q0.push_back(x); else q1.push_back(x);
  endtask

  task automatic wait_rsp(input int d, input string tag);
    int n = 0;
    while (!got[d] && n < 60) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
    chk(got[d], {tag, " response seen"}, {31'd0, got[d]}, 32'd1);
  endtask

  task automatic xfer(input int d, input bit w, input logic [31:0] a, input logic [31:0] wd,
                      input logic [3:0] s, input int mode, input int dly,
                      input logic [31:0] rdv, input bit exp_err, input logic [31:0] exp_rd,
                      input string tag);
    smode[d] = mode; sdelay[d] = dly; srd[d] = rdv;
    push(d, exp_err, exp_rd, tag);
    @(posedge clk); #2;
    clen[d] = 0; scnt[d] = 0; got[d] = 1'b0;
    req[d] = 1'b1; we[d] = w; addr[d] = a; wdata[d] = wd; ben[d] = s;
    @(negedge clk);
    // R11: registered request path opens the cycle one clock later, direct path at once
    chk(wcyc[d] == (d == 1), "R11 cycle at acceptance", {31'd0, wcyc[d]}, {31'd0, d == 1});
    @(posedge clk); #2;
    req[d] = 1'b0;
    wait_rsp(d, tag);
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      req[d] = 0; we[d] = 0; addr[d] = 0; wdata[d] = 0; ben[d] = 0;
      smode[d] = 0; sdelay[d] = 0; srd[d] = 0; clen[d] = 0; scnt[d] = 0;
      got[d] = 0; rcyc[d] = 0;
    end
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      // R1
      chk(!wcyc[d] && !wstb[d], "R1 cyc/stb low in reset", {30'd0, wcyc[d], wstb[d]}, 32'd0);
      chk(!rack[d] && !rerr[d] && ready[d], "R1 response idle, ready high",
          {29'd0, rack[d], rerr[d], ready[d]}, 32'd1);
    end
    @(posedge clk); #2 rst = 1'b0;

    // R2 R4 R10 classic read, little-endian
    xfer(0, 1'b0, 32'h0000_1000, 32'h0, 4'hF, 0, 2, 32'h1122_3344, 1'b0, 32'h1122_3344, "R4 classic read data");
    chk(clen[0] == 4, "R2 classic cycle length", clen[0], 4);
    chk(scnt[0] == clen[0], "R2 strobe follows cycle", scnt[0], clen[0]);
    chk(cadr[0] == 32'h0000_1000 && !cwe[0], "R4 read address and we", cadr[0], 32'h0000_1000);
    chk(rcyc[0] == 1'b0, "R10 registered response after cycle", {31'd0, rcyc[0]}, 32'd0);

    // R5 classic write
    xfer(0, 1'b1, 32'h0000_0100, 32'hAABB_CCDD, 4'b0110, 0, 0, 32'h0, 1'b0, 32'h0, "R5 write ack");
    chk(clen[0] == 2, "R5 write cycle length", clen[0], 2);
    chk(cdat[0] == 32'hAABB_CCDD, "R5 write data", cdat[0], 32'hAABB_CCDD);
    chk(csel[0] == 4'b0110 && cwe[0], "R5 byte select and we", {28'd0, csel[0]}, 32'd6);

    // R6 error response
    xfer(0, 1'b0, 32'h0000_2000, 32'h0, 4'hF, 1, 1, 32'hDEAD_0001, 1'b1, 32'h0, "R6 error classic");
    chk(clen[0] == 3, "R6 error cycle length", clen[0], 3);

    // R7 timeout with R12 held-off request
    smode[0] = 2;
    push(0, 1'b1, 32'h0, "R7 timeout fault");
    @(posedge clk); #2;
    clen[0] = 0; scnt[0] = 0; got[0] = 1'b0;
    req[0] = 1'b1; we[0] = 1'b0; addr[0] = 32'h0000_3000; ben[0] = 4'hF;
    @(posedge clk); #2;
    addr[0] = 32'h0000_4000;
    @(negedge clk);
    chk(!ready[0], "R12 ready low while busy", {31'd0, ready[0]}, 32'd0);
    chk(wadr[0] == 32'h0000_3000, "R12 new request ignored", wadr[0], 32'h0000_3000);
    @(posedge clk); #2 req[0] = 1'b0;
    wait_rsp(0, "R7 timeout");
    chk(clen[0] == 6, "R7 cycle length equals limit", clen[0], 6);
    chk(!wcyc[0], "R7 cycle dropped", {31'd0, wcyc[0]}, 32'd0);

    // R3 R9 R10 pipelined big-endian read
    xfer(1, 1'b0, 32'h0000_0040, 32'h0, 4'hF, 0, 1, 32'h1122_3344, 1'b0, 32'h4433_2211, "R9 big-endian read");
    chk(scnt[1] == 1, "R3 single strobe", scnt[1], 1);
    chk(clen[1] == 3, "R3 cycle held until ack", clen[1], 3);
    chk(rcyc[1] == 1'b1, "R10 direct response during cycle", {31'd0, rcyc[1]}, 32'd1);

    // R9 big-endian write
    xfer(1, 1'b1, 32'h0000_0044, 32'hAABB_CCDD, 4'b0011, 0, 0, 32'h0, 1'b0, 32'h0, "R9 big-endian write");
    chk(cdat[1] == 32'hDDCC_BBAA, "R9 write lanes reversed", cdat[1], 32'hDDCC_BBAA);
    chk(csel[1] == 4'b1100, "R9 select reversed", {28'd0, csel[1]}, 32'hC);

    // R6 error in pipelined mode
    xfer(1, 1'b0, 32'h0000_0048, 32'h0, 4'hF, 1, 2, 32'h5555_0000, 1'b1, 32'h0, "R6 error pipelined");
    chk(scnt[1] == 1, "R3 single strobe on error", scnt[1], 1);

    // R8 no timeout
    smode[1] = 2;
    push(1, 1'b0, 32'h0403_0201, "R8 late ack after stall");
    @(posedge clk); #2;
    got[1] = 1'b0;
    req[1] = 1'b1; we[1] = 1'b0; addr[1] = 32'h0000_0050; ben[1] = 4'hF;
    @(posedge clk); #2 req[1] = 1'b0;
    repeat (40) @(negedge clk);
    chk(wcyc[1], "R8 cycle still open", {31'd0, wcyc[1]}, 32'd1);
    chk(!got[1], "R8 no response while stalled", {31'd0, got[1]}, 32'd0);
    srd[1] = 32'h0102_0304; sdelay[1] = 0; smode[1] = 0;
    wait_rsp(1, "R8 stall release");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule